// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a programmed number of words between one peripheral and system memory without the processor handling each word. Software first loads a start address and a word count through a small register port, then writes a control word. The control word sets the direction, selects the bus policy, and starts the run. Once started, the engine waits for the peripheral to raise its request. It then asks for the system bus and, after the grant arrives, drives the memory address with a read or write strobe for each word. The same strobe is returned to the peripheral as its acknowledge.

Two bus policies are offered. In the holding policy the engine keeps its bus request high from the first word to the last, even while the peripheral pauses. In the stealing policy it lets go of the bus after every word for a configurable number of cycles, so the processor can win arbitration between words. The address steps up by one per word and the count steps down by one. When the count reaches zero the run ends, the bus request falls, and a sticky interrupt flag is raised. That flag holds until software clears it.

Top module: `dmac_engine`

## Requirements
- R1: After reset `bus_req`, `mem_rd`, `mem_wr`, `mem_addr_en`, `per_ack` and `irq` are low, and the address, count and control registers read back as zero.
- R2: While no run is active, a write with `reg_sel`=0 loads the address and `reg_sel`=1 loads the count, and both read back unchanged. Reads are combinational on `reg_sel`.
- R3: A write with `reg_sel`=2 and bit 0 set starts a run only when the count is non-zero. Control readback shows bit 0 = active, bit 1 = direction, bit 2 = stealing policy and bit 4 = interrupt flag. `bus_req` rises on the clock edge after an active run sees `per_req` high.
- R4: `mem_rd`, `mem_wr`, `per_ack` and `mem_addr_en` are never high while `bus_grant` is low. A word moves only in a cycle where `bus_req`, `bus_grant` and `per_req` are all high.
- R5: With control bit 1 = 0, words are read from memory (`mem_rd`) and `per_wdata` equals `mem_rdata`. With bit 1 = 1, words are written to memory (`mem_wr`) and `mem_wdata` equals `per_rdata`. The two strobes are never high together.
- R6: The address increases by one after each word, wrapping modulo 2^AW. After a run it reads back as start + count.
- R7: Exactly the programmed number of words moves, and the count reads back as zero afterwards.
- R8: With control bit 2 = 0, `bus_req` stays high from the start of the run until the last word, including while `per_req` is low.
- R9: With control bit 2 = 1, `bus_req` is low for at least STEAL_GAP cycles (default 1) after every word that is not the last.
- R10: On the clock edge after the last word, `bus_req` falls and `irq` rises.
- R11: `irq` stays high until an idle write with `reg_sel`=2 and bit 3 set clears it.
- R12: Register writes made while a run is active have no effect on the address, the count or the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data for `reg_sel` |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_addr | output | AW | Memory address |
| mem_addr_en | output | 1 | Address valid, only under grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Data returned by memory |
| mem_wdata | output | DW | Data written to memory |
| per_req | input | 1 | Peripheral has or wants a word |
| per_ack | output | 1 | Word moved this cycle |
| per_rdata | input | DW | Data offered by the peripheral |
| per_wdata | output | DW | Data delivered to the peripheral |
| irq | output | 1 | Sticky end-of-run interrupt |

## Verification
Strobes, the acknowledge and the data paths are combinational in the cycle where grant and peripheral request meet. The bench therefore compares each word against the queued expectation at the falling edge of that same cycle. `bus_req` and `irq` are registered state, so the bench samples them one falling edge after their cause: one edge after `per_req` for the request, and one edge after the last strobe for the drop and the interrupt. Register readback is combinational and is sampled one time step after `reg_sel` is set. The monitor also counts the falling edges with `bus_req` low between consecutive words, which separates the two bus policies.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // register select codes
   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   // control / status bit positions
   localparam int CTL_GO    = 0;  // write: start, read: active
   localparam int CTL_DIR   = 1;  // 1 = peripheral to memory
   localparam int CTL_STEAL = 2;  // 1 = release bus after each word
   localparam int CTL_CLR   = 3;  // write 1: clear interrupt flag
   localparam int STS_DONE  = 4;  // read: interrupt flag

   localparam int CTL_BITS  = 5;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_HOLD = 2'd1,
      SQ_GAP  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
   import dmac_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    sel,
   input  logic [RW-1:0] wr_data,
   input  logic          step,
   output logic [AW-1:0] cur_addr,
   output logic          active,
   output logic          cfg_dir,
   output logic          cfg_steal,
   output logic          last_word,
   output logic          done,
   output logic [RW-1:0] rd_data
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          dir_q, steal_q, busy_q, done_q;
   logic          idle_wr;

   assign idle_wr = wr_en && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         dir_q   <= 1'b0;
         steal_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (step) begin
         addr_q <= addr_q + 1'b1;
         cnt_q  <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end else if (idle_wr) begin
         case (sel)
            SEL_ADDR:  addr_q <= wr_data[AW-1:0];
            SEL_COUNT: cnt_q  <= wr_data[CW-1:0];
            SEL_CTRL: begin
               dir_q   <= wr_data[CTL_DIR];
               steal_q <= wr_data[CTL_STEAL];
               if (wr_data[CTL_GO] && (cnt_q != '0)) busy_q <= 1'b1;
               if (wr_data[CTL_CLR]) done_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_ADDR:  rd_data[AW-1:0] = addr_q;
         SEL_COUNT: rd_data[CW-1:0] = cnt_q;
         SEL_CTRL: begin
            rd_data[CTL_GO]    = busy_q;
            rd_data[CTL_DIR]   = dir_q;
            rd_data[CTL_STEAL] = steal_q;
            rd_data[STS_DONE]  = done_q;
         end
         default: ;
      endcase
   end

   assign cur_addr  = addr_q;
   assign active    = busy_q;
   assign cfg_dir   = dir_q;
   assign cfg_steal = steal_q;
   assign last_word = (cnt_q == CW'(1));
   assign done      = done_q;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
   import dmac_pkg::*;
#(
   parameter int STEAL_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cfg_dir,
   input  logic cfg_steal,
   input  logic last_word,
   input  logic per_req,
   input  logic bus_grant,
   output logic bus_req,
   output logic step,
   output logic addr_en,
   output logic rd_stb,
   output logic wr_stb
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int GW = $clog2(STEAL_GAP + 1) + 1;

   seq_state_e state_q, state_d;
   logic       gap_done;

   generate
      if (STEAL_GAP == 1) begin : g_gap_single
         assign gap_done = 1'b1;
      end else begin : g_gap_count
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                gap_q <= '0;
            else if (state_q != SQ_GAP) gap_q <= '0;
            else                       gap_q <= gap_q + 1'b1;
         end
         assign gap_done = (gap_q == GW'(STEAL_GAP - 1));
      end
   endgenerate

   assign bus_req = (state_q == SQ_HOLD);
   assign addr_en = bus_req && bus_grant;
   assign step    = addr_en && per_req;
   assign rd_stb  = step && !cfg_dir;
   assign wr_stb  = step && cfg_dir;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE: if (active && per_req) state_d = SQ_HOLD;
         SQ_HOLD: begin
            if (step) begin
               if (last_word)      state_d = SQ_IDLE;
               else if (cfg_steal) state_d = SQ_GAP;
            end
         end
         SQ_GAP: begin
            if (gap_done) state_d = per_req ? SQ_HOLD : SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
   import dmac_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int DW        = 16,
   parameter int STEAL_GAP = 1,
   localparam int RW       = (AW > CW) ? ((AW > CTL_BITS) ? AW : CTL_BITS)
                                       : ((CW > CTL_BITS) ? CW : CTL_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          bus_req,
   input  logic          bus_grant,
   output logic [AW-1:0] mem_addr,
   output logic          mem_addr_en,
   output logic          mem_rd,
   output logic          mem_wr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] mem_wdata,
   input  logic          per_req,
   output logic          per_ack,
   input  logic [DW-1:0] per_rdata,
   output logic [DW-1:0] per_wdata,
   output logic          irq
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (AW < 2)        begin : g_bad_aw  $error("AW must be at least 2");        end
      if (CW < 2)        begin : g_bad_cw  $error("CW must be at least 2");        end
      if (DW < 1)        begin : g_bad_dw  $error("DW must be at least 1");        end
      if (STEAL_GAP < 1) begin : g_bad_gap $error("STEAL_GAP must be at least 1"); end
   endgenerate

   logic step, active, cfg_dir, cfg_steal, last_word, done;

   dmac_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .sel       (reg_sel),
      .wr_data   (reg_wdata),
      .step      (step),
      .cur_addr  (mem_addr),
      .active    (active),
      .cfg_dir   (cfg_dir),
      .cfg_steal (cfg_steal),
      .last_word (last_word),
      .done      (done),
      .rd_data   (reg_rdata)
   );

   dmac_seq #(.STEAL_GAP(STEAL_GAP)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cfg_dir   (cfg_dir),
      .cfg_steal (cfg_steal),
      .last_word (last_word),
      .per_req   (per_req),
      .bus_grant (bus_grant),
      .bus_req   (bus_req),
      .step      (step),
      .addr_en   (mem_addr_en),
      .rd_stb    (mem_rd),
      .wr_stb    (mem_wr)
   );

   assign per_ack   = step;
   assign mem_wdata = mem_wr ? per_rdata : '0;
   assign per_wdata = mem_rd ? mem_rdata : '0;
   assign irq       = done;
endmodule

// File: rtl/dmac_engine_chk.sv
module dmac_engine_chk #(
   parameter int AW = 16,
   parameter int RW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [1:0]    reg_sel,
   input logic [RW-1:0] reg_wdata,
   input logic          bus_req,
   input logic          bus_grant,
   input logic [AW-1:0] mem_addr,
   input logic          mem_addr_en,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          per_ack,
   input logic          cfg_steal,
   input logic          last_word,
   input logic          irq
);
   timeunit 1ns;
   timeprecision 1ps;

   logic moved;
   assign moved = mem_rd || mem_wr;

   p_strobe_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (moved || per_ack) |-> (bus_grant && bus_req));

   p_addr_en_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |-> !mem_addr_en);

   p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      moved |=> (mem_addr == $past(mem_addr) + AW'(1)));

   p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !cfg_steal && !(moved && last_word)) |=> bus_req);

   p_steal_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (moved && cfg_steal) |=> !bus_req);

   p_end_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (moved && last_word) |=> (!bus_req && irq));

   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(reg_we && reg_sel == 2'd2 && reg_wdata[3])) |=> irq);
endmodule

bind dmac_engine dmac_engine_chk #(.AW(AW), .RW(RW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_sel     (reg_sel),
   .reg_wdata   (reg_wdata),
   .bus_req     (bus_req),
   .bus_grant   (bus_grant),
   .mem_addr    (mem_addr),
   .mem_addr_en (mem_addr_en),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .per_ack     (per_ack),
   .cfg_steal   (cfg_steal),
   .last_word   (last_word),
   .irq         (irq)
);

// File: tb/dmac_engine_bench.sv
module dmac_engine_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int RW = 16;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          wr;
      logic [DW-1:0] data;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          bus_req, bus_grant, mem_addr_en, mem_rd, mem_wr, per_ack, irq;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata, mem_wdata, per_rdata, per_wdata;
   logic          per_req = 1'b0;
   logic          cpu_hold = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   int pops     = 0;
   int low_cnt  = 0;
   bit first_word = 1'b1;
   bit cur_steal  = 1'b0;
   item_t exp_q[$];

   always #4 clk = ~clk;

   // memory and peripheral data derived from the address on the bus
   assign mem_rdata = mem_addr ^ 16'hA5A5;
   assign per_rdata = ~mem_addr;

   // processor-side arbiter: grants one cycle after request unless held off
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_grant <= 1'b0;
      else        bus_grant <= bus_req && !cpu_hold;
   end

   dmac_engine u_dmac_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_addr_en(mem_addr_en),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .per_req(per_req), .per_ack(per_ack),
      .per_rdata(per_rdata), .per_wdata(per_wdata), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [RW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [RW-1:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   // monitor: compares each moved word against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_addr_en && !bus_grant)
            chk(1'b0, "R4", "addr enable without grant", 32'(mem_addr_en), 32'd0);
         if (mem_rd || mem_wr) begin
            item_t e;
            chk(bus_grant && per_ack, "R4", "strobe without grant/ack",
                32'({bus_grant, per_ack}), 32'd3);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7", "unexpected extra word", 32'(mem_addr), 32'd0);
            end else begin
               e = exp_q.pop_front();
               pops++;
               chk(mem_addr == e.addr, "R6", "word address", 32'(mem_addr), 32'(e.addr));
               chk(mem_wr == e.wr && mem_rd == !e.wr, "R5", "strobe direction",
                   32'({mem_wr, mem_rd}), 32'({e.wr, !e.wr}));
               if (e.wr) chk(mem_wdata == e.data, "R5", "memory write data",
                             32'(mem_wdata), 32'(e.data));
               else      chk(per_wdata == e.data, "R5", "peripheral data",
                             32'(per_wdata), 32'(e.data));
            end
            if (!first_word) begin
               if (cur_steal) chk(low_cnt >= 1, "R9", "bus release between words",
                                  32'(low_cnt), 32'd1);
               else           chk(low_cnt == 0, "R8", "bus held between words",
                                  32'(low_cnt), 32'd0);
            end
            first_word = 1'b0;
            low_cnt = 0;
         end else if (!bus_req) begin
            low_cnt++;
         end
      end
   end

   task automatic run_block(input logic [AW-1:0] start, input int n, input bit wr,
                            input bit steal, input int hold, input bit pause,
                            input bit poke);
      logic [RW-1:0] rd;
      int base;
      reg_write(2'd0, RW'(start));
      reg_write(2'd1, RW'(n));
      for (int i = 0; i < n; i++) begin
         item_t it;
         it.addr = start + AW'(i);
         it.wr   = wr;
         it.data = wr ? ~it.addr : (it.addr ^ 16'hA5A5);
         exp_q.push_back(it);
      end
      cur_steal  = steal;
      first_word = 1'b1;
      low_cnt    = 0;
      base       = pops;
      cpu_hold   = (hold > 0);
      reg_write(2'd2, RW'({steal, wr, 1'b1}));
      reg_read(2'd2, rd);
      chk(rd[0] == 1'b1 && rd[1] == wr && rd[2] == steal, "R3", "control readback",
          32'(rd[2:0]), 32'({steal, wr, 1'b1}));
      chk(bus_req == 1'b0, "R3", "no request before peripheral", 32'(bus_req), 32'd0);
      per_req = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b1, "R3", "request one edge after per_req", 32'(bus_req), 32'd1);
      if (hold > 0) begin
         if (poke) begin
            reg_write(2'd0, 16'h1234);
            reg_write(2'd1, 16'h0077);
            reg_write(2'd2, 16'h0008);
         end
         repeat (hold) @(negedge clk);
         chk(bus_req && !mem_addr_en && !mem_rd && !mem_wr && !per_ack, "R4",
             "idle bus outputs while grant withheld",
             32'({bus_req, mem_addr_en, mem_rd, mem_wr, per_ack}), 32'h10);
         cpu_hold = 1'b0;
      end
      if (pause) begin
         wait (pops >= base + 2);
         @(negedge clk);
         per_req = 1'b0;
         repeat (3) @(negedge clk);
         chk(bus_req == 1'b1, "R8", "request held during peripheral pause",
             32'(bus_req), 32'd1);
         per_req = 1'b1;
      end
      for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "words left unmoved", 32'(exp_q.size()), 32'd0);
      @(negedge clk);
      chk(bus_req == 1'b0 && irq == 1'b1, "R10", "end of run drop/irq",
          32'({bus_req, irq}), 32'b01);
      per_req = 1'b0;
      reg_read(2'd1, rd);
      chk(rd == '0, "R7", "count after run", 32'(rd), 32'd0);
      reg_read(2'd0, rd);
      chk(rd[AW-1:0] == start + AW'(n), poke ? "R12" : "R6", "address after run",
          32'(rd), 32'(start + AW'(n)));
   endtask

   initial begin
      logic [RW-1:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!bus_req && !mem_rd && !mem_wr && !mem_addr_en && !per_ack && !irq, "R1",
          "outputs in reset", 32'({bus_req, mem_rd, mem_wr, mem_addr_en, per_ack, irq}), 32'd0);
      rst_n = 1'b1;
      for (int s = 0; s < 3; s++) begin
         reg_read(2'(s), rd);
         chk(rd == '0, "R1", "register after reset", 32'(rd), 32'd0);
      end
      // R2 idle loads
      reg_write(2'd0, 16'h0100);
      reg_read(2'd0, rd);
      chk(rd == 16'h0100, "R2", "address readback", 32'(rd), 32'h0100);
      reg_write(2'd1, 16'h0000);
      reg_read(2'd1, rd);
      chk(rd == 16'h0000, "R2", "count readback", 32'(rd), 32'h0);
      // R3 start with zero count is ignored
      reg_write(2'd2, 16'h0001);
      reg_read(2'd2, rd);
      chk(rd[0] == 1'b0, "R3", "zero-count start ignored", 32'(rd), 32'd0);
      per_req = 1'b1;
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0, "R3", "no request when not started", 32'(bus_req), 32'd0);
      per_req = 1'b0;

      // burst, memory read, grant delayed, busy writes, peripheral pause
      run_block(16'h0100, 6, 1'b0, 1'b0, 4, 1'b1, 1'b1);
      // R11 sticky flag
      reg_write(2'd2, 16'h0000);
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R11", "flag held without clear", 32'(irq), 32'd1);
      reg_write(2'd2, 16'h0008);
      chk(irq == 1'b0, "R11", "flag cleared", 32'(irq), 32'd0);

      // cycle steal, memory write, address wrap
      run_block(16'hFFFE, 4, 1'b1, 1'b1, 0, 1'b0, 1'b0);
      reg_write(2'd2, 16'h0008);
      // cycle steal, memory read
      run_block(16'h0040, 3, 1'b0, 1'b1, 0, 1'b0, 1'b0);
      reg_write(2'd2, 16'h0008);
      // burst, memory write
      run_block(16'h2000, 5, 1'b1, 1'b0, 0, 1'b0, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule